// File: doc/BRIEF.md
# Two-Frame Peripheral Bus Bridge

The bridge takes one access at a time from a wide internal memory bus and runs it on a simple peripheral bus. That bus has 16 address lines, a 32-bit data path, a read/write line, a one-cycle strobe and one select line per frame. The internal address is split into two parts. Its low 16 bits become the peripheral address. Its upper bits are compared with two configurable ranges, and the result picks one of two frames.

The wide frame accepts 16-bit and 32-bit transfers in a single strobe cycle. The narrow frame is a legacy frame that only has a 16-bit data lane. A 32-bit access to the narrow frame is split into two strobe cycles: the low half goes first at the given address, and the high half follows at the next address. An access whose upper bits match neither range never reaches the peripheral bus. It completes at once with an error flag and zero read data.

The requester raises `req_valid` with the access fields and holds them until `rsp_done` pulses. The bridge latches the fields when it accepts the access. It returns read data with the done pulse.

Top module: `pbus_bridge`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes, `pb_stb`, `pb_sel_wide`, `pb_sel_narrow` and `rsp_done` are low.
- R2: An access whose upper address bits (bits 21:16 at default width) lie in [WIDE_LO, WIDE_HI] drives `pb_sel_wide` during its strobe. `pb_addr` equals the request's bits 15:0. The wide range wins if the two ranges overlap.
- R3: An access whose upper bits lie in [NARROW_LO, NARROW_HI], and not in the wide range, drives `pb_sel_narrow` during its strobe.
- R4: A 16-bit access (`req_wide`=0) to either frame uses exactly one strobe cycle. `rsp_done` rises two clock edges after the edge that accepts the request. Read data is the peripheral's `pb_rdata[15:0]`, zero-extended. A write drives `pb_wdata` = {16'h0, req_wdata[15:0]}.
- R5: A 32-bit access to the wide frame uses one strobe cycle with `pb_wide`=1. It moves all 32 bits of `pb_wdata` or `pb_rdata`, and done comes with the timing of R4.
- R6: A 32-bit access to the narrow frame uses two consecutive strobe cycles with `pb_wide`=0. The first cycle is at the request address with data bits 15:0. The second is at that address plus one (mod 2^16) with data bits 31:16 on `pb_wdata[15:0]`. Read data is {second pb_rdata[15:0], first pb_rdata[15:0]}. Done rises three edges after acceptance.
- R7: An access matching neither frame produces no strobe. `rsp_done` rises one edge after acceptance, with `rsp_err`=1 and `rsp_rdata`=0.
- R8: `rsp_done` is high for exactly one cycle. Changes on the request inputs between acceptance and done have no effect on the access in flight.
- R9: Both frame selects are low whenever `pb_stb` is low, and exactly one is high while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request, held until done |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 32-bit, 0 = 16-bit |
| req_addr | input | ADDR_W | Internal access address |
| req_wdata | input | 32 | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Access hit no frame (valid with done) |
| rsp_rdata | output | 32 | Read data (valid with done) |
| pb_stb | output | 1 | Peripheral transfer strobe |
| pb_sel_wide | output | 1 | Wide frame select |
| pb_sel_narrow | output | 1 | Narrow frame select |
| pb_wr | output | 1 | Peripheral write when strobed |
| pb_wide | output | 1 | 32-bit transfer on the wide frame |
| pb_addr | output | 16 | Peripheral address |
| pb_wdata | output | 32 | Peripheral write data |
| pb_rdata | input | 32 | Peripheral read data, valid during strobe |

## Verification
The assertions assume that the peripheral returns stable read data for the whole strobe cycle. They also assume that the requester keeps `req_valid` high until it sees `rsp_done` and then drops it or presents a new access. The bench models the peripheral combinationally from `pb_addr`. It changes request inputs only on falling edges, and it lowers `req_valid` on the cycle where done is observed, so each access is accepted exactly once. One directed case changes the address and size fields in the middle of a split access to show that the latched copy is used.

// File: rtl/pbb_pkg.sv
package pbb_pkg;
  localparam int unsigned PA_W = 16;
  localparam int unsigned DW   = 32;
  localparam int unsigned HW   = DW / 2;

  typedef enum logic [1:0] {FR_NONE, FR_WIDE, FR_NARROW} frame_e;
  typedef enum logic [1:0] {ST_IDLE, ST_STB1, ST_STB2, ST_DONE} state_e;
endpackage

// File: rtl/pbb_decode.sv
module pbb_decode
  import pbb_pkg::*;
#(
  parameter int unsigned UP_W      = 6,
  parameter int unsigned WIDE_LO   = 1,
  parameter int unsigned WIDE_HI   = 1,
  parameter int unsigned NARROW_LO = 2,
  parameter int unsigned NARROW_HI = 3
) (
  input  logic [UP_W-1:0] up_bits,
  output frame_e          frame
);
  localparam logic [UP_W-1:0] W_LO = WIDE_LO[UP_W-1:0];
  localparam logic [UP_W-1:0] W_HI = WIDE_HI[UP_W-1:0];
  localparam logic [UP_W-1:0] N_LO = NARROW_LO[UP_W-1:0];
  localparam logic [UP_W-1:0] N_HI = NARROW_HI[UP_W-1:0];

  logic hit_w, hit_n;

  always_comb begin
    hit_w = (up_bits >= W_LO) && (up_bits <= W_HI);
    hit_n = (up_bits >= N_LO) && (up_bits <= N_HI);
    if (hit_w)      frame = FR_WIDE;
    else if (hit_n) frame = FR_NARROW;
    else            frame = FR_NONE;
  end
endmodule

// File: rtl/pbb_rdcap.sv
module pbb_rdcap
  import pbb_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          ld_lo,
  input  logic          ld_full,
  input  logic          ld_hi,
  input  logic [DW-1:0] pb_rdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] rd_d, rd_q;

  always_comb begin
    rd_d = rd_q;
    if (clr)          rd_d = '0;
    else if (ld_full) rd_d = pb_rdata;
    else if (ld_lo)   rd_d = {rd_q[DW-1:HW], pb_rdata[HW-1:0]};
    else if (ld_hi)   rd_d = {pb_rdata[HW-1:0], rd_q[HW-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;
endmodule

// File: rtl/pbb_seq.sv
module pbb_seq
  import pbb_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            req_wide,
  input  logic [PA_W-1:0] req_paddr,
  input  logic [DW-1:0]   req_wdata,
  input  frame_e          req_frame,
  output logic            rsp_done,
  output logic            rsp_err,
  output logic            pb_stb,
  output logic            pb_sel_wide,
  output logic            pb_sel_narrow,
  output logic            pb_wr,
  output logic            pb_wide,
  output logic [PA_W-1:0] pb_addr,
  output logic [DW-1:0]   pb_wdata,
  output logic            cap_clr,
  output logic            cap_lo,
  output logic            cap_full,
  output logic            cap_hi
);
  state_e          st_q, st_d;
  frame_e          fr_q;
  logic            wr_q, wide_q, accept, split;
  logic [PA_W-1:0] addr_q;
  logic [DW-1:0]   wd_q;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign split  = (fr_q == FR_NARROW) && wide_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (req_valid) st_d = (req_frame == FR_NONE) ? ST_DONE : ST_STB1;
      ST_STB1: st_d = split ? ST_STB2 : ST_DONE;
      ST_STB2: st_d = ST_DONE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fr_q   <= FR_NONE;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        fr_q   <= req_frame;
        wr_q   <= req_write;
        wide_q <= req_wide;
        addr_q <= req_paddr;
        wd_q   <= req_wdata;
      end
    end
  end

  always_comb begin
    pb_stb        = (st_q == ST_STB1) || (st_q == ST_STB2);
    pb_sel_wide   = pb_stb && (fr_q == FR_WIDE);
    pb_sel_narrow = pb_stb && (fr_q == FR_NARROW);
    pb_wr         = pb_stb && wr_q;
    pb_wide       = pb_sel_wide && wide_q;
    pb_addr       = (st_q == ST_STB2) ? addr_q + 1'b1 : addr_q;
    if (st_q == ST_STB2) pb_wdata = {{HW{1'b0}}, wd_q[DW-1:HW]};
    else if (pb_wide)    pb_wdata = wd_q;
    else                 pb_wdata = {{HW{1'b0}}, wd_q[HW-1:0]};
    rsp_done = (st_q == ST_DONE);
    rsp_err  = rsp_done && (fr_q == FR_NONE);
    cap_clr  = accept;
    cap_full = (st_q == ST_STB1) && pb_wide;
    cap_lo   = (st_q == ST_STB1) && !pb_wide;
    cap_hi   = (st_q == ST_STB2);
  end

  // R6
  split_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STB2) |-> (pb_addr == $past(pb_addr) + 16'd1) && $past(pb_stb));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R8
  held_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_stb && $past(pb_stb)) |-> $stable(pb_sel_wide) && $stable(pb_wr));

  // R5
  wide_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pb_wide |-> pb_sel_wide && !pb_sel_narrow);

  // R4
  single_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_stb && !pb_wide && !wide_q) |=> !pb_stb);
endmodule

// File: rtl/pbus_bridge.sv
module pbus_bridge
  import pbb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 22,
  parameter int unsigned WIDE_LO   = 1,
  parameter int unsigned WIDE_HI   = 1,
  parameter int unsigned NARROW_LO = 2,
  parameter int unsigned NARROW_HI = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_wide,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_done,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata,
  output logic              pb_stb,
  output logic              pb_sel_wide,
  output logic              pb_sel_narrow,
  output logic              pb_wr,
  output logic              pb_wide,
  output logic [15:0]       pb_addr,
  output logic [31:0]       pb_wdata,
  input  logic [31:0]       pb_rdata
);
  localparam int unsigned UP_W = ADDR_W - PA_W;

  logic [1:0] rst_sync;
  logic       rst_q;
  frame_e     frame;
  logic       cap_clr, cap_lo, cap_full, cap_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  pbb_decode #(
    .UP_W(UP_W), .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI),
    .NARROW_LO(NARROW_LO), .NARROW_HI(NARROW_HI)
  ) u_decode (
    .up_bits(req_addr[ADDR_W-1:PA_W]),
    .frame  (frame)
  );

  pbb_seq u_seq (
    .clk(clk), .rst_n(rst_q),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_paddr(req_addr[PA_W-1:0]), .req_wdata(req_wdata), .req_frame(frame),
    .rsp_done(rsp_done), .rsp_err(rsp_err),
    .pb_stb(pb_stb), .pb_sel_wide(pb_sel_wide), .pb_sel_narrow(pb_sel_narrow),
    .pb_wr(pb_wr), .pb_wide(pb_wide), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .cap_clr(cap_clr), .cap_lo(cap_lo), .cap_full(cap_full), .cap_hi(cap_hi)
  );

  pbb_rdcap u_rdcap (
    .clk(clk), .rst_n(rst_q), .clr(cap_clr), .ld_lo(cap_lo),
    .ld_full(cap_full), .ld_hi(cap_hi), .pb_rdata(pb_rdata), .rdata(rsp_rdata)
  );

  // R7
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_done && rsp_err) |-> (rsp_rdata == 32'h0) && !$past(pb_stb));

  // R4
  done_after_stb_chk: assert property (@(posedge clk) disable iff (!rst_q)
    (rsp_done && !rsp_err) |-> $past(pb_stb));

  // R9
  sel_gate_chk: assert property (@(posedge clk) disable iff (!rst_q)
    !pb_stb |-> !pb_sel_wide && !pb_sel_narrow);
endmodule

// File: tb/pbus_bridge_tb.sv
module pbus_bridge_tb;
  typedef struct packed {
    logic        wr;
    logic        wide;
    logic [21:0] addr;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  lat;
    logic [3:0]  nstb;
    logic [1:0]  sel;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 22'h010040, 32'h0,        32'h00000040, 1'b0, 4'd2, 4'd1, 2'b01},
    '{1'b0, 1'b1, 22'h010080, 32'h0,        32'hFF7F0080, 1'b0, 4'd2, 4'd1, 2'b01},
    '{1'b0, 1'b0, 22'h020010, 32'h0,        32'h00000010, 1'b0, 4'd2, 4'd1, 2'b10},
    '{1'b0, 1'b1, 22'h020100, 32'h0,        32'h01010100, 1'b0, 4'd3, 4'd2, 2'b10},
    '{1'b0, 1'b1, 22'h050000, 32'h0,        32'h00000000, 1'b1, 4'd1, 4'd0, 2'b00},
    '{1'b1, 1'b1, 22'h01FFF0, 32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 4'd2, 4'd1, 2'b01},
    '{1'b1, 1'b1, 22'h030004, 32'h12345678, 32'h12345678, 1'b0, 4'd3, 4'd2, 2'b10},
    '{1'b1, 1'b0, 22'h02000A, 32'hCAFE1234, 32'h00001234, 1'b0, 4'd2, 4'd1, 2'b10},
    '{1'b1, 1'b0, 22'h000010, 32'h55AA55AA, 32'h00000000, 1'b1, 4'd1, 4'd0, 2'b00}
  };

  logic        clk, rst_n, req_valid, req_write, req_wide;
  logic [21:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata, pb_wdata, pb_rdata;
  logic        rsp_done, rsp_err, pb_stb, pb_sel_wide, pb_sel_narrow, pb_wr, pb_wide;
  logic [15:0] pb_addr;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int stb_cnt, wr_cnt, gate_bad;
  logic [1:0]  sel_seen;
  logic        wide_seen;
  logic [31:0] wlog;
  logic [15:0] addr0, addr1;

  pbus_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_wide(req_wide), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .pb_stb(pb_stb), .pb_sel_wide(pb_sel_wide), .pb_sel_narrow(pb_sel_narrow),
    .pb_wr(pb_wr), .pb_wide(pb_wide), .pb_addr(pb_addr), .pb_wdata(pb_wdata),
    .pb_rdata(pb_rdata)
  );

  assign pb_rdata = {~pb_addr, pb_addr};

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!pb_stb && (pb_sel_wide || pb_sel_narrow)) gate_bad++;
    if (pb_stb) begin
      if (stb_cnt == 0) begin
        wlog  = pb_wdata;
        addr0 = pb_addr;
      end else begin
        wlog[31:16] = pb_wdata[15:0];
        addr1 = pb_addr;
      end
      stb_cnt++;
      if (pb_wr) wr_cnt++;
      sel_seen = sel_seen | {pb_sel_narrow, pb_sel_wide};
      if (pb_wide) wide_seen = 1'b1;
    end
    if (cyc > 5000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected <5000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic issue(input vec_t v, output int lat);
    @(negedge clk);
    stb_cnt = 0; wr_cnt = 0; sel_seen = 2'b00; wide_seen = 1'b0; wlog = '0;
    req_valid = 1'b1; req_write = v.wr; req_wide = v.wide;
    req_addr = v.addr; req_wdata = v.wd;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      lat++;
      if (rsp_done) break;
    end
    req_valid = 1'b0;
  endtask

  initial begin
    int lat;
    vec_t v;
    gate_bad = 0; stb_cnt = 0; wr_cnt = 0; sel_seen = 2'b00; wide_seen = 1'b0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_wide = 1'b0;
    req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1 outputs quiet during reset
    chk(!pb_stb && !rsp_done && !pb_sel_wide && !pb_sel_narrow, "R1",
        {28'h0, pb_stb, rsp_done, pb_sel_wide, pb_sel_narrow}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pb_stb && !rsp_done, "R1", {30'h0, pb_stb, rsp_done}, 32'h0);
    repeat (3) @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      v = VECS[k];
      issue(v, lat);
      // R2 R3 R4 R5 R6 R7 latency, strobe count, frame select, data
      chk(rsp_done, "R8 done seen", {31'h0, rsp_done}, 32'h1);
      chk(rsp_err == v.err, "R7 err flag", {31'h0, rsp_err}, {31'h0, v.err});
      chk(lat == int'(v.lat), "R4/R6 latency", lat, {28'h0, v.lat});
      chk(stb_cnt == int'(v.nstb), "R6 strobe count", stb_cnt, {28'h0, v.nstb});
      chk(sel_seen == v.sel, "R2/R3 frame select", {30'h0, sel_seen}, {30'h0, v.sel});
      chk(wide_seen == (v.wide && v.sel == 2'b01), "R5 wide flag",
          {31'h0, wide_seen}, {31'h0, v.wide && v.sel == 2'b01});
      if (!v.wr || v.err)
        chk(rsp_rdata == v.exp, "R4/R5/R6/R7 read data", rsp_rdata, v.exp);
      else
        chk(wlog == v.exp, "R4/R5/R6 write data", wlog, v.exp);
      if (v.nstb != 0)
        chk(addr0 == v.addr[15:0], "R2 peripheral address", {16'h0, addr0}, {16'h0, v.addr[15:0]});
      if (v.nstb == 2)
        chk(addr1 == v.addr[15:0] + 16'd1, "R6 second address", {16'h0, addr1}, {16'h0, v.addr[15:0] + 16'd1});
      @(negedge clk);
      // R8 done lasts one cycle
      chk(!rsp_done, "R8 done pulse", {31'h0, rsp_done}, 32'h0);
    end

    // R8 inputs changed mid-access are ignored
    @(negedge clk);
    stb_cnt = 0; wr_cnt = 0; sel_seen = 2'b00;
    req_valid = 1'b1; req_write = 1'b0; req_wide = 1'b1; req_addr = 22'h020200;
    @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_wide = 1'b0; req_addr = 22'h010000; req_wdata = 32'hFFFFFFFF;
    lat = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (rsp_done) break;
    end
    req_valid = 1'b0;
    chk(rsp_rdata == 32'h02010200, "R8 held read data", rsp_rdata, 32'h02010200);
    chk(wr_cnt == 0, "R8 no write strobe", wr_cnt, 32'h0);
    chk(addr1 == 16'h0201, "R8 held second address", {16'h0, addr1}, 32'h0201);
    chk(sel_seen == 2'b10, "R8 held frame", {30'h0, sel_seen}, 32'h2);

    // R6 address wrap at top of peripheral space
    v = '{1'b0, 1'b1, 22'h02FFFF, 32'h0, 32'h0000FFFF, 1'b0, 4'd3, 4'd2, 2'b10};
    issue(v, lat);
    chk(rsp_rdata == v.exp, "R6 wrap read", rsp_rdata, v.exp);
    chk(addr1 == 16'h0000, "R6 wrap address", {16'h0, addr1}, 32'h0);

    @(negedge clk);
    // R9 selects gated by strobe across the whole run
    chk(gate_bad == 0, "R9 select gating", gate_bad, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule